// File: doc/BRIEF.md
# Receive Character Queue with Idle Timeout

This block holds received serial characters until the host collects them. A deserializer offers each character as a one-cycle `rx_valid` beat, or it reports a line break on `rx_break`. The block stores the character in a 16-entry queue, or in a single holding register when queueing is switched off. It keeps the data-ready, break and overrun status, reports a programmable trigger level, and raises a character-timeout flag when data has waited for four character times without host activity. The character time comes from the live line format and a clock divisor.

The incoming stream has no ready signal, because a serial line cannot be paused. Back-pressure therefore becomes a loss policy. In queue mode a character that meets a full queue is dropped and overrun is flagged. In single-register mode the old character is overwritten. The outgoing side is show-ahead: `rd_data` always presents the oldest character, or zero when nothing is stored, and a `host_rd` pulse consumes it at the next clock edge. Configuration and status are plain level pins.

Top module: `rx_char_queue`

## Requirements
- R1: After reset the fill level is 0, queue mode is off, data ready, break, overrun and timeout are all 0, `rd_data` is 0 and the trigger level is 1.
- R2: A configuration write sets the trigger level from `cfg_trig`, where code 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14.
- R3: In queue mode, a character arriving while 16 characters are stored and none is read that cycle is discarded. The stored characters are kept and overrun is set.
- R4: In queue mode, characters are delivered on `rd_data` in arrival order, and `fill_level` equals the number stored.
- R5: With queue mode off, each character overwrites the holding register and sets data ready. Overrun is set if data ready was already set and no read happens in the same cycle. `fill_level` stays 0.
- R6: A break stores a zero character and sets both break and data ready.
- R7: A read from an empty queue returns 0. In queue mode, data ready tracks a non-empty queue, and data ready and break clear when a read empties the queue.
- R8: In queue mode, every stored character and every read that leaves data behind restarts a window of 4 character times. When the window ends with data stored, the timeout flag rises exactly 64 × frame bits × max(divisor,1) clocks after the restarting edge.
- R9: Any data read clears the timeout flag.
- R10: Frame bits = 1 + (`fmt_data[1:0]` + 5) + `fmt_data[3]` + (2 if `fmt_data[2]` else 1). Bits are 16 divisor ticks, and a divisor of 0 acts as 1.
- R11: A write with `cfg_flush` set, or one that changes `cfg_enable`, empties the queue and clears data ready, break, the timeout flag and the running window.
- R12: A line-status read clears break and overrun. Data ready is not affected.
- R13: A flush takes priority over a character or a read in the same cycle: that character is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received character beat |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Break event, stored as a zero character |
| host_rd | input | 1 | Host consumes the presented character |
| rd_data | output | 8 | Oldest character (show-ahead), 0 if empty |
| lsr_rd | input | 1 | Line-status read, clears break and overrun |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Queue mode enable value |
| cfg_flush | input | 1 | Flush request |
| cfg_trig | input | 2 | Trigger code |
| fmt_we | input | 1 | Line-format write strobe |
| fmt_data | input | 4 | Length code [1:0], extra stop [2], parity [3] |
| divisor | input | 16 | Clocks per baud tick |
| fill_level | output | 5 | Characters stored |
| trig_level | output | 4 | Trigger level in bytes |
| fifo_on | output | 1 | Queue mode active |
| data_ready | output | 1 | Data available |
| break_seen | output | 1 | Break status |
| overrun | output | 1 | Overrun status |
| char_timeout | output | 1 | Character timeout flag |

## Verification
The properties assume that reset is applied before the first beat. They also assume that `rx_valid`, `rx_break`, `host_rd`, `lsr_rd` and configuration writes are single-cycle strobes, which may coincide in any combination. The stimulus drives every strobe for one cycle between clock edges and often overlaps arrivals with reads, including at a full queue. It changes the line format and divisor only while no timeout window is running, so each expected expiry cycle is well defined. During the random phase the divisor is held at its maximum, so no timeout can interfere with the queue-order checks.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int MAX_FRAME = 12;

  // trigger code -> bytes
  function automatic logic [3:0] trig_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd4;
      2'd2:    return 4'd8;
      default: return 4'd14;
    endcase
  endfunction

  // start + data + optional parity + one or two stop bits
  function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
    return 4'd7 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]} + {3'b000, fmt[2]};
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  wire do_pop  = pop && (count != '0);
  wire do_push = push && ((count != FULLV) || do_pop);

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= (wp == LASTP) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == LASTP) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rp];

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLV);
  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count == '0) |=> count == '0);
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer import rxq_pkg::*; #(
  parameter int DIV_W         = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int CHAR_SPAN     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             cancel,
  input  logic [DIV_W-1:0] divisor,
  input  logic [3:0]       fmt,
  output logic             expire
);
  localparam int SPAN = TICKS_PER_BIT * CHAR_SPAN;
  localparam int TW   = $clog2(MAX_FRAME * SPAN + 1);

  logic             armed;
  logic [DIV_W-1:0] pre;
  logic [TW-1:0]    ticks;

  wire [DIV_W-1:0] div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
  wire [TW-1:0]    limit   = TW'(frame_bits(fmt)) * TW'(SPAN);
  wire             tick    = armed && (pre == div_eff - DIV_W'(1));

  assign expire = tick && (ticks == limit - TW'(1)) && !restart && !cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; pre <= '0; ticks <= '0;
    end else if (cancel) begin
      armed <= 1'b0; pre <= '0; ticks <= '0;
    end else if (restart) begin
      armed <= 1'b1; pre <= '0; ticks <= '0;
    end else if (expire) begin
      armed <= 1'b0; pre <= '0; ticks <= '0;
    end else if (tick) begin
      pre <= '0; ticks <= ticks + TW'(1);
    end else if (armed) begin
      pre <= pre + DIV_W'(1);
    end
  end

  assert_restart_holds_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !cancel) |=> !expire);
  assert_cancel_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !expire);
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue import rxq_pkg::*; #(
  parameter int DEPTH         = 16,
  parameter int DIV_W         = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int CHAR_SPAN     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_valid,
  input  logic [7:0]                   rx_data,
  input  logic                         rx_break,
  input  logic                         host_rd,
  output logic [7:0]                   rd_data,
  input  logic                         lsr_rd,
  input  logic                         cfg_we,
  input  logic                         cfg_enable,
  input  logic                         cfg_flush,
  input  logic [1:0]                   cfg_trig,
  input  logic                         fmt_we,
  input  logic [3:0]                   fmt_data,
  input  logic [DIV_W-1:0]             divisor,
  output logic [$clog2(DEPTH+1)-1:0]   fill_level,
  output logic [3:0]                   trig_level,
  output logic                         fifo_on,
  output logic                         data_ready,
  output logic                         break_seen,
  output logic                         overrun,
  output logic                         char_timeout
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic          fifo_en;
  logic [1:0]    trig_code;
  logic [3:0]    fmt_q;
  logic [7:0]    hold_q;
  logic          dr_q, bi_q, oe_q, to_q;
  logic [7:0]    head;
  logic [CW-1:0] count;
  logic          tmr_expire;

  // flush: explicit request or a mode change
  wire flush     = cfg_we && (cfg_flush || (cfg_enable != fifo_en));
  wire arrive    = (rx_valid || rx_break) && !flush;
  wire [7:0] in_byte = rx_break ? 8'h00 : rx_data;

  wire q_push    = fifo_en && arrive;
  wire q_pop     = fifo_en && host_rd && !flush && (count != '0);
  wire q_drop    = q_push && (count == FULLV) && !q_pop;
  wire hold_push = !fifo_en && arrive;

  wire ovr_event = q_drop || (hold_push && dr_q && !host_rd);
  wire brk_event = arrive && rx_break;
  wire emptied   = fifo_en ? (q_pop && count == ONE && !q_push)
                           : (host_rd && !hold_push && !flush);

  wire tmr_restart = q_push || (q_pop && (count > ONE || q_push));

  rxq_store #(.DEPTH(DEPTH), .W(8)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .pop   (q_pop),
    .flush (flush),
    .din   (in_byte),
    .head  (head),
    .count (count)
  );

  rxq_timer #(.DIV_W(DIV_W), .TICKS_PER_BIT(TICKS_PER_BIT), .CHAR_SPAN(CHAR_SPAN)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .cancel  (flush),
    .divisor (divisor),
    .fmt     (fmt_q),
    .expire  (tmr_expire)
  );

  // configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en   <= 1'b0;
      trig_code <= 2'd0;
      fmt_q     <= 4'd0;
    end else begin
      if (cfg_we) begin
        fifo_en   <= cfg_enable;
        trig_code <= cfg_trig;
      end
      if (fmt_we) fmt_q <= fmt_data;
    end
  end

  // holding register for single-character mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= 8'h00;
    else if (hold_push) hold_q <= in_byte;
  end

  // status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= 1'b0; bi_q <= 1'b0; oe_q <= 1'b0; to_q <= 1'b0;
    end else begin
      if (flush)                 dr_q <= 1'b0;
      else if (arrive)           dr_q <= 1'b1;
      else if (emptied)          dr_q <= 1'b0;

      if (flush)                 bi_q <= 1'b0;
      else if (brk_event)        bi_q <= 1'b1;
      else if (emptied || lsr_rd) bi_q <= 1'b0;

      if (ovr_event)             oe_q <= 1'b1;
      else if (lsr_rd)           oe_q <= 1'b0;

      if (flush || host_rd)      to_q <= 1'b0;
      else if (tmr_expire && count != '0) to_q <= 1'b1;
    end
  end

  assign rd_data      = fifo_en ? ((count == '0) ? 8'h00 : head) : hold_q;
  assign fill_level   = count;
  assign trig_level   = trig_bytes(trig_code);
  assign fifo_on      = fifo_en;
  assign data_ready   = dr_q;
  assign break_seen   = bi_q;
  assign overrun      = oe_q;
  assign char_timeout = to_q;

  assert_drop_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (rx_valid || rx_break) && count == FULLV && !host_rd && !cfg_we)
      |=> (count == FULLV) && overrun);
  assert_ready_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |-> (dr_q == (count != '0)));
  assert_timeout_has_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> (count != '0));
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> !char_timeout);
  assert_lsr_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid && !rx_break) |=> (!overrun && !break_seen));
  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && !data_ready);
endmodule

// File: tb/rx_char_queue_test.sv
`timescale 1ns/1ps
module rx_char_queue_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        rx_valid, rx_break, host_rd, lsr_rd;
  logic [7:0]  rx_data, rd_data;
  logic        cfg_we, cfg_enable, cfg_flush;
  logic [1:0]  cfg_trig;
  logic        fmt_we;
  logic [3:0]  fmt_data;
  logic [15:0] divisor;
  logic [4:0]  fill_level;
  logic [3:0]  trig_level;
  logic        fifo_on, data_ready, break_seen, overrun, char_timeout;

  rx_char_queue uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .host_rd(host_rd), .rd_data(rd_data), .lsr_rd(lsr_rd),
    .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_flush(cfg_flush),
    .cfg_trig(cfg_trig), .fmt_we(fmt_we), .fmt_data(fmt_data), .divisor(divisor),
    .fill_level(fill_level), .trig_level(trig_level), .fifo_on(fifo_on),
    .data_ready(data_ready), .break_seen(break_seen), .overrun(overrun),
    .char_timeout(char_timeout)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] mq[$];
  bit m_ovr;
  bit dp, dr;
  logic [7:0] b;
  int n;

  function automatic int trig_expect(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int frame_expect(input logic [3:0] f);
    return 1 + (int'(f[1:0]) + 5) + int'(f[3]) + (f[2] ? 2 : 1);
  endfunction

  function automatic int window_clocks(input logic [3:0] f, input int dv);
    return frame_expect(f) * 16 * 4 * ((dv == 0) ? 1 : dv);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v);
    rx_valid = 1'b1; rx_data = v;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_break();
    rx_break = 1'b1;
    @(negedge clk);
    rx_break = 1'b0;
  endtask

  task automatic read_expect(input string req, input int exp);
    chk(req, rd_data, exp);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic line_status_read();
    lsr_rd = 1'b1;
    @(negedge clk);
    lsr_rd = 1'b0;
  endtask

  task automatic cfg_write(input bit en, input bit fl, input logic [1:0] tr);
    cfg_we = 1'b1; cfg_enable = en; cfg_flush = fl; cfg_trig = tr;
    @(negedge clk);
    cfg_we = 1'b0; cfg_flush = 1'b0;
  endtask

  task automatic fmt_write(input logic [3:0] f);
    fmt_we = 1'b1; fmt_data = f;
    @(negedge clk);
    fmt_we = 1'b0;
  endtask

  task automatic wait_clk(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; rx_valid = 0; rx_break = 0; host_rd = 0; lsr_rd = 0;
    rx_data = 0; cfg_we = 0; cfg_enable = 0; cfg_flush = 0; cfg_trig = 0;
    fmt_we = 0; fmt_data = 0; divisor = 16'hFFFF;
    wait_clk(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 fill", fill_level, 0);
    chk("R1 fifo_on", fifo_on, 0);
    chk("R1 ready", data_ready, 0);
    chk("R1 break", break_seen, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 timeout", char_timeout, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 trig", trig_level, 1);

    // R2 trigger codes
    for (int c = 0; c < 4; c++) begin
      cfg_write(1'b1, 1'b0, 2'(c));
      chk("R2 trigger level", trig_level, trig_expect(c));
    end
    chk("R2 queue mode on", fifo_on, 1);

    // R4 random stream in queue mode
    fmt_write(4'h3);
    m_ovr = 0;
    for (int i = 0; i < 500; i++) begin
      dp = ($urandom % 100) < 55;
      dr = ($urandom % 100) < 45;
      b  = 8'($urandom);
      if (dr) chk("R4 read order", rd_data, (mq.size() == 0) ? 0 : int'(mq[0]));
      rx_valid = dp; rx_data = b; host_rd = dr;
      @(negedge clk);
      rx_valid = 0; host_rd = 0;
      if (dr && mq.size() > 0) void'(mq.pop_front());
      if (dp) begin
        if (mq.size() < DEPTH) mq.push_back(b);
        else m_ovr = 1;
      end
      chk("R4 fill level", fill_level, mq.size());
      chk("R7 ready tracks data", data_ready, int'(mq.size() != 0));
      chk("R3 overrun model", overrun, int'(m_ovr));
    end

    // R3 directed full-queue drop
    cfg_write(1'b1, 1'b1, 2'd0);
    line_status_read();
    chk("R11 flush empties", fill_level, 0);
    for (int i = 0; i < 17; i++) push(8'(8'h40 + i));
    chk("R3 fill at capacity", fill_level, 16);
    chk("R3 overrun set", overrun, 1);
    for (int i = 0; i < 16; i++) read_expect("R3 kept contents", 8'h40 + i);
    chk("R7 ready cleared", data_ready, 0);

    // R12 line-status read clears overrun
    line_status_read();
    chk("R12 overrun cleared", overrun, 0);

    // R7 empty read
    read_expect("R7 empty read returns 0", 0);
    chk("R7 fill still 0", fill_level, 0);

    // R6 break
    send_break();
    chk("R6 break fill", fill_level, 1);
    chk("R6 break bit", break_seen, 1);
    chk("R6 break ready", data_ready, 1);
    read_expect("R6 break byte zero", 0);
    chk("R7 break clears on empty", break_seen, 0);
    chk("R7 ready clears on empty", data_ready, 0);

    // R12 line-status read clears break, keeps data ready
    send_break();
    line_status_read();
    chk("R12 break cleared", break_seen, 0);
    chk("R12 ready kept", data_ready, 1);

    // R8 / R10 timeout, 5 data bits no parity one stop, divisor 2
    cfg_write(1'b1, 1'b1, 2'd0);
    fmt_write(4'h0);
    divisor = 16'd2;
    n = window_clocks(4'h0, 2);
    push(8'hA1);
    wait_clk(n - 1);
    chk("R8 R10 not yet expired", char_timeout, 0);
    wait_clk(2);
    chk("R8 R10 expired", char_timeout, 1);
    read_expect("R9 data under timeout", 8'hA1);
    chk("R9 read clears timeout", char_timeout, 0);

    // R8 restart by new byte and by read, 8 data, parity, two stop, divisor 1
    fmt_write(4'hF);
    divisor = 16'd1;
    n = window_clocks(4'hF, 1);
    push(8'h11);
    wait_clk(300);
    push(8'h22);
    wait_clk(n - 1);
    chk("R8 restart by byte", char_timeout, 0);
    wait_clk(2);
    chk("R8 R10 expiry long frame", char_timeout, 1);
    read_expect("R8 head", 8'h11);
    chk("R9 cleared", char_timeout, 0);
    wait_clk(n - 1);
    chk("R8 restart by read", char_timeout, 0);
    wait_clk(2);
    chk("R8 expiry after read", char_timeout, 1);

    // R11 flush clears timeout state
    cfg_write(1'b1, 1'b1, 2'd0);
    chk("R11 flush timeout", char_timeout, 0);
    chk("R11 flush fill", fill_level, 0);

    // R10 divisor 0 acts as 1
    fmt_write(4'h3);
    divisor = 16'd0;
    n = window_clocks(4'h3, 0);
    push(8'h33);
    wait_clk(n - 1);
    chk("R10 zero divisor early", char_timeout, 0);
    wait_clk(2);
    chk("R10 zero divisor expiry", char_timeout, 1);
    divisor = 16'hFFFF;

    // R13 flush beats same-cycle byte
    push(8'h44);
    rx_valid = 1'b1; rx_data = 8'h55;
    cfg_write(1'b1, 1'b1, 2'd0);
    rx_valid = 1'b0;
    chk("R13 flush priority fill", fill_level, 0);
    chk("R13 flush priority ready", data_ready, 0);

    // R11 mode change forces flush
    push(8'h66); push(8'h77);
    cfg_write(1'b0, 1'b0, 2'd0);
    chk("R11 mode change fill", fill_level, 0);
    chk("R11 mode change ready", data_ready, 0);
    chk("R11 mode off", fifo_on, 0);

    // R5 single register mode
    line_status_read();
    push(8'h81);
    chk("R5 ready", data_ready, 1);
    chk("R5 data", rd_data, 8'h81);
    chk("R5 no overrun", overrun, 0);
    push(8'h82);
    chk("R5 overwritten", rd_data, 8'h82);
    chk("R5 overrun", overrun, 1);
    chk("R5 level stays 0", fill_level, 0);
    read_expect("R5 read", 8'h82);
    chk("R5 ready cleared", data_ready, 0);
    line_status_read();
    push(8'h83);
    rx_valid = 1'b1; rx_data = 8'h84; host_rd = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; host_rd = 1'b0;
    chk("R5 read same cycle no overrun", overrun, 0);
    chk("R5 newest held", rd_data, 8'h84);
    chk("R5 ready after", data_ready, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule